// File: doc/BRIEF.md
# Paged Effective Address Generator

This block resolves the operand address of a memory-reference instruction for a 12-bit single-address processor. The 4096-word memory is divided into 32 pages of 128 words. The instruction supplies a 7-bit offset inside a page, a page-select flag and an indirect flag. The page is either page zero or the page that holds the program counter (its upper five bits). A direct reference produces the address at once. An indirect reference reads one pointer word from memory, and that word is the final address.

Eight page-zero cells, at octal 0010 to 0017, act as auto-index pointers. When an indirect reference lands on one of them, the block increments the stored word by one, modulo 4096. It writes the new value back and uses it as the address. A direct reference to those cells leaves them unchanged. The block also returns a 3-bit field number for extended memory. Direct results and the pointer access use the instruction field. Indirect results use the data field.

The sequencer issues memory reads and writes over a simple strobe/ready port. It accepts a new request only while idle and marks each result with a one-cycle done pulse.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset, done, busy, mem_rd and mem_wr are all 0.
- R2: In a direct reference with the page flag clear (MSB-first instruction bit 4, port bit instr[7], equal to 0), the result is {5'b0, instr[6:0]}.
- R3: In a direct reference with the page flag set (instr[7]=1), the result is {pc[11:7], instr[6:0]}.
- R4: A direct reference (indirect flag, MSB-first bit 3, port bit instr[8], equal to 0) makes no memory access. Its done pulse comes in the cycle after acceptance, with ea_field equal to the instruction field.
- R5: An indirect reference (instr[8]=1) reads the word at the R2/R3 address, in the instruction field. That word, unchanged, is the result, with ea_field equal to the data field. Only one level of indirection is applied.
- R6: An indirect reference whose R2/R3 address lies in 8..15 (octal 0010..0017) writes the read word plus one, modulo 4096, back to that address. The incremented value is the result.
- R7: An indirect reference to any other address, and any direct reference, including one to 8..15, causes no memory write.
- R8: mem_rd or mem_wr, once raised, stays high with mem_addr unchanged until the cycle in which mem_ready is 1.
- R9: busy is 1 from acceptance until done. A request presented while busy is ignored. mem_rd and mem_wr are never both 1.
- R10: done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Program counter |
| inst_field | input | 3 | Instruction field number |
| data_field | input | 3 | Data field number |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result valid, one-cycle pulse |
| ea | output | 12 | Effective address |
| ea_field | output | 3 | Field number for the effective address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address |
| mem_field | output | 3 | Memory field for the access |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current access |

## Verification
A wrong latched offset or page bit shows up as a bad ea at the very next done pulse. A stuck auto-index flag shows up in two ways: an ea off by one, and a missing or extra memory write before done. The bench catches the write by comparing its memory image after each request. A sequencer that drops its strobe early, or accepts a request while busy, changes mem_addr or the result within the same request. A sequencer that fails to return to idle trips the per-request latency limit after a few dozen cycles.

// File: rtl/pea_pkg.sv
package pea_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_BUMP  = 2'd2,
        ST_FIN   = 2'd3
    } pea_state_e;
endpackage

// File: rtl/pea_decode.sv
module pea_decode #(
    parameter int AW        = 12,
    parameter int OW        = 7,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] direct_addr,
    output logic          is_indirect,
    output logic          in_auto
);
    localparam int PW       = AW - OW;
    localparam int IND_BIT  = AW - 4;
    localparam int PAGE_BIT = AW - 5;
    localparam logic [AW-1:0] LO = AW'(AUTO_BASE);
    localparam logic [AW-1:0] HI = AW'(AUTO_BASE + AUTO_CNT);

    logic          cur_page;
    logic [PW-1:0] page_num;

    always_comb begin
        cur_page    = instr[PAGE_BIT];
        is_indirect = instr[IND_BIT];
        page_num    = cur_page ? pc[AW-1:OW] : '0;
        direct_addr = {page_num, instr[OW-1:0]};
        in_auto     = (direct_addr >= LO) && (direct_addr < HI);
    end
endmodule

// File: rtl/pea_incr.sv
module pea_incr #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] word_in,
    output logic [AW-1:0] word_out
);
    always_comb begin
        word_out = word_in + AW'(1);
    end
endmodule

// File: rtl/pea_seq.sv
module pea_seq
    import pea_pkg::*;
#(
    parameter int AW        = 12,
    parameter int FW        = 3,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] dec_addr,
    input  logic          dec_ind,
    input  logic          dec_auto,
    input  logic [FW-1:0] inst_field,
    input  logic [FW-1:0] data_field,
    input  logic [AW-1:0] mem_rdata,
    input  logic [AW-1:0] rdata_inc,
    input  logic          mem_ready,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [FW-1:0] ea_field,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [FW-1:0] mem_field,
    output logic [AW-1:0] mem_wdata
);
    localparam logic [AW-1:0] LO = AW'(AUTO_BASE);
    localparam logic [AW-1:0] HI = AW'(AUTO_BASE + AUTO_CNT);

    typedef struct packed {
        pea_state_e    st;
        logic [AW-1:0] ptr;
        logic [AW-1:0] res;
        logic          bump;
        logic [FW-1:0] ptr_fld;
        logic [FW-1:0] res_fld;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.ptr     = dec_addr;
                    r_d.res     = dec_addr;
                    r_d.bump    = dec_ind && dec_auto;
                    r_d.ptr_fld = inst_field;
                    r_d.res_fld = dec_ind ? data_field : inst_field;
                    r_d.st      = dec_ind ? ST_FETCH : ST_FIN;
                end
            end
            ST_FETCH: begin
                if (mem_ready) begin
                    r_d.res = r_q.bump ? rdata_inc : mem_rdata;
                    r_d.st  = r_q.bump ? ST_BUMP : ST_FIN;
                end
            end
            ST_BUMP: begin
                if (mem_ready) begin
                    r_d.st = ST_FIN;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ptr: '0, res: '0, bump: 1'b0,
                     ptr_fld: '0, res_fld: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        done      = (r_q.st == ST_FIN);
        ea        = r_q.res;
        ea_field  = r_q.res_fld;
        mem_rd    = (r_q.st == ST_FETCH);
        mem_wr    = (r_q.st == ST_BUMP);
        mem_addr  = r_q.ptr;
        mem_field = r_q.ptr_fld;
        mem_wdata = r_q.res;
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R8
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_WR_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ((mem_addr >= LO) && (mem_addr < HI))); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
    parameter int AW        = 12,
    parameter int OW        = 7,
    parameter int FW        = 3,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] pc,
    input  logic [FW-1:0] inst_field,
    input  logic [FW-1:0] data_field,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [FW-1:0] ea_field,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [FW-1:0] mem_field,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ready
);
    logic [AW-1:0] dec_addr;
    logic          dec_ind;
    logic          dec_auto;
    logic [AW-1:0] rdata_inc;

    pea_decode #(
        .AW(AW), .OW(OW), .AUTO_BASE(AUTO_BASE), .AUTO_CNT(AUTO_CNT)
    ) u_decode (
        .instr       (instr),
        .pc          (pc),
        .direct_addr (dec_addr),
        .is_indirect (dec_ind),
        .in_auto     (dec_auto)
    );

    pea_incr #(.AW(AW)) u_incr (
        .word_in  (mem_rdata),
        .word_out (rdata_inc)
    );

    pea_seq #(
        .AW(AW), .FW(FW), .AUTO_BASE(AUTO_BASE), .AUTO_CNT(AUTO_CNT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .dec_addr   (dec_addr),
        .dec_ind    (dec_ind),
        .dec_auto   (dec_auto),
        .inst_field (inst_field),
        .data_field (data_field),
        .mem_rdata  (mem_rdata),
        .rdata_inc  (rdata_inc),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .done       (done),
        .ea         (ea),
        .ea_field   (ea_field),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_field  (mem_field),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: tb/paged_ea_gen_tb_top.sv
`timescale 1ns/1ps
module paged_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] pc = '0;
    logic [2:0]  inst_field = '0;
    logic [2:0]  data_field = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [11:0] ea, mem_addr, mem_wdata;
    logic [2:0]  ea_field, mem_field;
    logic [11:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    int wr_count = 0;
    int strobe_cycles = 0;
    int hold_errs = 0;
    int fld_errs = 0;
    int lat = 0;
    bit finished = 0;
    logic [2:0]  cur_if = '0;
    logic        prev_rd = 0, prev_wr = 0, prev_rdy = 0;
    logic [11:0] prev_addr = '0;
    logic [11:0] mem [4096];

    always #4 clk = ~clk;

    paged_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .pc(pc), .inst_field(inst_field), .data_field(data_field),
        .busy(busy), .done(done), .ea(ea), .ea_field(ea_field),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_field(mem_field), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: ready after a random wait, one cycle wide
    always @(negedge clk) begin
        if (rst_n) begin
            if ((prev_rd || prev_wr) && !prev_rdy &&
                (!(mem_rd || mem_wr) || mem_addr != prev_addr ||
                 mem_rd != prev_rd)) hold_errs++;
            if (mem_rd && mem_field != cur_if) fld_errs++;
            if (mem_rd || mem_wr) strobe_cycles++;
        end
        if (mem_ready) begin
            mem_ready = 1'b0;
            lat = int'($urandom % 3);
        end else if (mem_rd || mem_wr) begin
            if (lat == 0) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr];
            end else lat--;
        end
        prev_rd = mem_rd; prev_wr = mem_wr; prev_rdy = mem_ready;
        prev_addr = mem_addr;
    end

    always @(posedge clk) begin
        if (mem_wr && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [11:0] ins, input logic [11:0] p,
                          input logic [2:0] fi, input logic [2:0] fd,
                          input bit poke);
        logic [11:0] a, w, exp_ea, exp_mem;
        logic [2:0]  exp_f;
        bit ind, auto_c;
        int cycles, wr0, st0;
        a      = ins[7] ? {p[11:7], ins[6:0]} : {5'b0, ins[6:0]};
        ind    = ins[8];
        auto_c = ind && (a >= 12'd8) && (a <= 12'd15);
        w      = mem[a];
        exp_mem = auto_c ? w + 12'd1 : w;
        exp_ea = ind ? exp_mem : a;
        exp_f  = ind ? fd : fi;
        @(negedge clk);
        wr0 = wr_count; st0 = strobe_cycles; cur_if = fi;
        req_valid = 1; instr = ins; pc = p; inst_field = fi; data_field = fd;
        @(negedge clk);
        cycles = 1;
        check(busy == 1'b1, "R9", "busy after accept", busy, 1);
        req_valid = poke;
        if (poke) begin
            instr = 12'($urandom); pc = 12'($urandom);
            inst_field = 3'($urandom); data_field = 3'($urandom);
        end
        while (!done && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        req_valid = 0;
        check(done == 1'b1, "R9", "done seen", done, 1);
        check(ea == exp_ea, ind ? (auto_c ? "R6" : "R5") : (ins[7] ? "R3" : "R2"),
              "ea", ea, exp_ea);
        check(ea_field == exp_f, ind ? "R5" : "R4", "ea_field", ea_field, exp_f);
        if (!ind) begin
            check(cycles == 1, "R4", "direct latency", cycles, 1);
            check(strobe_cycles == st0, "R4", "direct mem strobes",
                  strobe_cycles - st0, 0);
        end
        check((wr_count - wr0) == (auto_c ? 1 : 0), auto_c ? "R6" : "R7",
              "write count", wr_count - wr0, auto_c ? 1 : 0);
        check(mem[a] == exp_mem, auto_c ? "R6" : "R7", "stored word",
              mem[a], exp_mem);
        @(negedge clk);
        check(done == 1'b0, "R10", "done pulse width", done, 0);
        check(busy == 1'b0, "R9", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 12'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 0 && busy == 0, "R1", "done/busy in reset", {done, busy}, 0);
        check(mem_rd == 0 && mem_wr == 0, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1;
        @(negedge clk);
        check(done == 0 && busy == 0, "R1", "idle after reset", {done, busy}, 0);
        // directed corners
        run_op(12'o0055, 12'o3456, 3'd1, 3'd2, 0);        // R2 direct page zero
        run_op(12'o0255, 12'o3456, 3'd3, 3'd4, 0);        // R3 direct current page
        run_op(12'o0012, 12'o1000, 3'd1, 3'd5, 0);        // R7 direct auto cell
        mem[12'o0040] = 12'o1234;
        run_op(12'o0440, 12'o7000, 3'd2, 3'd6, 0);        // R5 indirect page zero
        mem[12'o5177] = 12'o0017;
        run_op(12'o0777, 12'o5100, 3'd0, 3'd7, 1);        // R5 single level, poke R9
        mem[12'o0010] = 12'o0100;
        run_op(12'o0410, 12'o2000, 3'd4, 3'd1, 0);        // R6 first auto cell
        mem[12'o0017] = 12'o7777;
        run_op(12'o0417, 12'o2000, 3'd4, 3'd1, 0);        // R6 wrap
        run_op(12'o0407, 12'o2000, 3'd4, 3'd1, 0);        // R7 below range
        run_op(12'o0420, 12'o2000, 3'd4, 3'd1, 0);        // R7 above range
        run_op(12'o0613, 12'o0123, 3'd2, 3'd3, 0);        // R6 current page 0
        run_op(12'o0613, 12'o4123, 3'd2, 3'd3, 0);        // R5 current page 4xx
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [11:0] ri;
            ri = 12'($urandom);
            if (($urandom % 4) == 0) ri[6:0] = 7'(8 + ($urandom % 8));
            run_op(ri, 12'($urandom), 3'($urandom), 3'($urandom), ($urandom % 2) == 1);
        end
        check(hold_errs == 0, "R8", "strobe/address hold violations", hold_errs, 0);
        check(fld_errs == 0, "R5", "pointer field mismatches", fld_errs, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule